// File: doc/BRIEF.md
# Slow Reference Clock Frequency Comparator

This block decides which of two slow reference clocks (kHz range) runs faster. It measures each one with a much faster system clock (MHz range). Each reference input is brought into the system clock domain through a synchroniser chain, and a one-cycle pulse is produced for each of its rising and falling edges. A per-channel counter then measures a chosen span of that reference in system clock cycles. The span is either the high phase (rise to fall) or the whole period (rise to next rise). When the span ends, the count is latched and a per-channel capture flag is set.

Once both channels hold a fresh capture, the comparator orders the two counts and sets exactly one of three verdict outputs: A faster, B faster, or equal. It also emits a single-cycle event pulse that an interrupt controller can pick up. Both capture flags are cleared when the verdict is taken. The verdict is held until the next comparison. The high-phase mode gives a correct answer only when both references have a 50% duty cycle. The full-period mode is for references with any other duty cycle.

Top module: `slowclk_compare`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge (synchronous, active low), all three verdict outputs and `cmp_event_o` read 0 after that edge, and all measurement state is discarded.
- R2: With `full_period_i` = 0, a channel's count is the number of `clk` cycles between the synchronised rising edge of its reference and the next synchronised falling edge. A falling edge that arrives while no measurement is open is ignored.
- R3: With `full_period_i` = 1, a channel's count is the number of `clk` cycles between two consecutive synchronised rising edges, and falling edges have no effect.
- R4: No comparison and no event occur until both channels have captured a count since the last comparison. A channel that captures again before its partner keeps only its latest count.
- R5: When the two captured counts are equal, `equal_o` is set.
- R6: When channel A's count is larger than channel B's, `b_faster_o` is set.
- R7: When channel A's count is smaller than channel B's, `a_faster_o` is set.
- R8: At most one of `a_faster_o`, `b_faster_o`, `equal_o` is high at any time, and they change only in a cycle where `cmp_event_o` is high.
- R9: Each comparison raises `cmp_event_o` for one cycle. In that same cycle, exactly one verdict output carries the new result.
- R10: A measurement counter stops at 2^CNT_W-1 instead of wrapping, so any span of that length or longer reads as 2^CNT_W-1. Two such channels compare as equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_a_i | input | 1 | Slow reference clock A, asynchronous to `clk` |
| ref_b_i | input | 1 | Slow reference clock B, asynchronous to `clk` |
| full_period_i | input | 1 | 0: measure high phase; 1: measure full period |
| a_faster_o | output | 1 | Verdict: reference A has the higher frequency |
| b_faster_o | output | 1 | Verdict: reference B has the higher frequency |
| equal_o | output | 1 | Verdict: both counts are identical |
| cmp_event_o | output | 1 | One-cycle pulse per completed comparison |

## Verification
The properties assume that each reference input holds every level for several system clock cycles, well beyond the synchroniser depth, so that no edge is lost or merged. They also assume that `full_period_i` changes only while reset is applied. The stimulus drives both references on the falling edge of `clk`, with high and low widths of at least ten cycles. It switches the span mode and waveform shapes only around a reset pulse. Before each reset it waits long enough for the previous waveform to drain, so every measured span belongs to one known waveform.

// File: rtl/scmp_pkg.sv
// Package: shared types of the slow-clock comparator.
// Assumes nothing; holds only enumerations used across the sub-blocks.
package scmp_pkg;

    // Which portion of a reference cycle a channel measures.
    typedef enum logic {
        SPAN_HIGH   = 1'b0,   // rising edge to falling edge
        SPAN_PERIOD = 1'b1    // rising edge to next rising edge
    } span_mode_e;

    // Held result of the most recent comparison.
    typedef enum logic [1:0] {
        VERDICT_NONE   = 2'd0,
        VERDICT_A_FAST = 2'd1,
        VERDICT_B_FAST = 2'd2,
        VERDICT_EQUAL  = 2'd3
    } verdict_e;

endpackage

// File: rtl/scmp_edge_detect.sv
// Module: scmp_edge_detect
// Brings one asynchronous slow reference into the clk domain through a
// STAGES-deep flop chain and emits single-cycle rise and fall pulses.
// Assumes the reference holds each level for more than STAGES+1 clk cycles.
module scmp_edge_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES:0]   feed;
    logic              level;
    logic              prev_q;

    assign feed  = {chain_q, async_i};
    assign level = feed[STAGES];

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= feed[STAGES-1:0];
        end
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    // Edge pulses are combinational from two registered levels.
    always_comb begin
        rise_o = level & ~prev_q;
        fall_o = ~level & prev_q;
    end

endmodule

// File: rtl/scmp_span_meter.sv
// Module: scmp_span_meter
// Counts clk cycles over one span of a synchronised reference (high phase or
// full period), latches the count when the span ends and raises a done flag
// that stays up until the comparator clears it. The count saturates.
// Assumes rise_i and fall_i never pulse in the same cycle and that mode_i
// is static outside reset.
module scmp_span_meter
    import scmp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  span_mode_e       mode_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] run_cnt_q;
    logic [CNT_W-1:0] held_q;
    logic             open_q;
    logic             done_q;
    logic             span_end;

    // A span ends on the edge that matches the mode, only if one is open.
    always_comb begin
        if (mode_i == SPAN_PERIOD) begin
            span_end = open_q & rise_i;
        end else begin
            span_end = open_q & fall_i;
        end
    end

    // Running counter: restart on rise, stop on high-phase end, else count up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt_q <= '0;
            open_q    <= 1'b0;
        end else if (rise_i) begin
            run_cnt_q <= CNT_ONE;
            open_q    <= 1'b1;
        end else if (span_end) begin
            run_cnt_q <= '0;
            open_q    <= 1'b0;
        end else if (open_q && (run_cnt_q != CNT_MAX)) begin
            run_cnt_q <= run_cnt_q + CNT_ONE;
        end
    end

    // Latch the finished count; later captures overwrite earlier ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (span_end) begin
            held_q <= run_cnt_q;
        end
    end

    // Capture flag: a new capture wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (span_end) begin
            done_q <= 1'b1;
        end else if (clear_i) begin
            done_q <= 1'b0;
        end
    end

    assign count_o = held_q;
    assign done_o  = done_q;

endmodule

// File: rtl/scmp_judge.sv
// Module: scmp_judge
// Waits until both channels report a capture, then orders the two counts,
// stores a one-of-three verdict, pulses an event for one cycle and clears
// the capture flags. Assumes the counts are stable while their flags are up.
module scmp_judge
    import scmp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_a_i,
    input  logic [CNT_W-1:0] count_b_i,
    input  logic             done_a_i,
    input  logic             done_b_i,
    output logic             clear_o,
    output logic             a_fast_o,
    output logic             b_fast_o,
    output logic             equal_o,
    output logic             event_o
);

    verdict_e verdict_q;
    verdict_e verdict_next;
    logic     event_q;
    logic     both_ready;

    assign both_ready = done_a_i & done_b_i;
    assign clear_o    = both_ready;

    // Order the counts: a longer span means a lower frequency.
    always_comb begin
        if (count_a_i == count_b_i) begin
            verdict_next = VERDICT_EQUAL;
        end else if (count_a_i > count_b_i) begin
            verdict_next = VERDICT_B_FAST;
        end else begin
            verdict_next = VERDICT_A_FAST;
        end
    end

    // Hold the verdict between comparisons and pulse the event once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= VERDICT_NONE;
            event_q   <= 1'b0;
        end else begin
            event_q <= both_ready;
            if (both_ready) begin
                verdict_q <= verdict_next;
            end
        end
    end

    // Decode the stored verdict into the three exclusive outputs.
    always_comb begin
        a_fast_o = (verdict_q == VERDICT_A_FAST);
        b_fast_o = (verdict_q == VERDICT_B_FAST);
        equal_o  = (verdict_q == VERDICT_EQUAL);
        event_o  = event_q;
    end

endmodule

// File: rtl/slowclk_compare.sv
// Module: slowclk_compare
// Top of the slow reference clock comparator: two synchronised channels,
// each with an edge detector and a span meter, feeding one judge.
// Assumes clk is many times faster than either reference.
module slowclk_compare
    import scmp_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_a_i,
    input  logic ref_b_i,
    input  logic full_period_i,
    output logic a_faster_o,
    output logic b_faster_o,
    output logic equal_o,
    output logic cmp_event_o
);

    localparam int unsigned NCH = 2;

    span_mode_e       span_mode;
    logic [NCH-1:0]   ref_vec;
    logic [NCH-1:0]   rise_vec;
    logic [NCH-1:0]   fall_vec;
    logic [NCH-1:0]   done_vec;
    logic [CNT_W-1:0] count_arr [NCH];
    logic             clear_all;

    assign span_mode = span_mode_e'(full_period_i);
    assign ref_vec   = {ref_b_i, ref_a_i};

    // One identical measurement channel per reference input.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        scmp_edge_detect #(
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (ref_vec[ch]),
            .rise_o  (rise_vec[ch]),
            .fall_o  (fall_vec[ch])
        );

        scmp_span_meter #(
            .CNT_W (CNT_W)
        ) u_meter (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_i  (span_mode),
            .rise_i  (rise_vec[ch]),
            .fall_i  (fall_vec[ch]),
            .clear_i (clear_all),
            .count_o (count_arr[ch]),
            .done_o  (done_vec[ch])
        );
    end

    scmp_judge #(
        .CNT_W (CNT_W)
    ) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_a_i (count_arr[0]),
        .count_b_i (count_arr[1]),
        .done_a_i  (done_vec[0]),
        .done_b_i  (done_vec[1]),
        .clear_o   (clear_all),
        .a_fast_o  (a_faster_o),
        .b_fast_o  (b_faster_o),
        .equal_o   (equal_o),
        .event_o   (cmp_event_o)
    );

endmodule

// File: rtl/scmp_checker.sv
// Module: scmp_checker
// Temporal properties of the comparator, attached to the top by bind.
// Assumes the stimulus rules stated in the brief.
module scmp_checker (
    input logic clk,
    input logic rst_n,
    input logic a_fast,
    input logic b_fast,
    input logic same,
    input logic evt,
    input logic done_a,
    input logic done_b
);

    // R8: the three verdict outputs never overlap.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_fast, b_fast, same}));

    // R8: the verdict is held while no comparison completes.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |-> $stable({a_fast, b_fast, same}));

    // R9: an event always carries exactly one verdict.
    a_r9_event_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> ($countones({a_fast, b_fast, same}) == 1));

    // R4: two ready channels lead to an event on the next cycle.
    a_r4_both_ready_event: assert property (@(posedge clk) disable iff (!rst_n)
        (done_a && done_b) |=> evt);

    // R4: an event is never raised without two captures before it.
    a_r4_event_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(done_a && done_b));

endmodule

bind slowclk_compare scmp_checker u_scmp_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_fast (a_faster_o),
    .b_fast (b_faster_o),
    .same   (equal_o),
    .evt    (cmp_event_o),
    .done_a (done_vec[0]),
    .done_b (done_vec[1])
);

// File: tb/slowclk_compare_bench.sv
module slowclk_compare_bench;

    localparam int CNT_W = 8;
    localparam int SYNC  = 2;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_a = 1'b0;
    logic ref_b = 1'b0;
    logic full_period = 1'b0;
    logic a_faster, b_faster, equal_w, cmp_event;

    int vectors = 0;
    int misses = 0;
    bit finished = 1'b0;

    int hi_a = 20, lo_a = 20, hi_b = 30, lo_b = 30;
    bit en_a = 1'b1, en_b = 1'b1;
    int evt_seen = 0;

    always #5 clk = ~clk;

    slowclk_compare #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC)
    ) u_slowclk_compare (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_a_i       (ref_a),
        .ref_b_i       (ref_b),
        .full_period_i (full_period),
        .a_faster_o    (a_faster),
        .b_faster_o    (b_faster),
        .equal_o       (equal_w),
        .cmp_event_o   (cmp_event)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference waveform generators, driven on the falling clk edge.
    initial forever begin
        if (en_a) begin
            ref_a = 1'b1;
            repeat (hi_a) @(negedge clk);
            ref_a = 1'b0;
            repeat (lo_a) @(negedge clk);
        end else begin
            ref_a = 1'b0;
            @(negedge clk);
        end
    end

    initial forever begin
        if (en_b) begin
            ref_b = 1'b1;
            repeat (hi_b) @(negedge clk);
            ref_b = 1'b0;
            repeat (lo_b) @(negedge clk);
        end else begin
            ref_b = 1'b0;
            @(negedge clk);
        end
    end

    // Behavioural reference model: edge times, spans and a pending-pair rule.
    bit hq_a[$];
    bit hq_b[$];
    int m_open[2], m_start[2], m_meas[2], m_done[2];
    int cyc = 0;
    logic [2:0] e_res = 3'b000;   // {a_faster, b_faster, equal}
    bit e_evt = 1'b0;
    bit model_ok = 1'b0;

    always @(posedge clk) begin : ref_model
        int lvl[2];
        int prv[2];
        bit both;
        bit rs;
        bit fl;
        bit cap;
        cyc++;
        if (!rst_n) begin
            hq_a.delete();
            hq_b.delete();
            repeat (SYNC + 1) begin
                hq_a.push_front(1'b0);
                hq_b.push_front(1'b0);
            end
            for (int ch = 0; ch < 2; ch++) begin
                m_open[ch] = 0; m_start[ch] = 0; m_meas[ch] = 0; m_done[ch] = 0;
            end
            e_res = 3'b000;
            e_evt = 1'b0;
        end else begin
            hq_a.push_front(ref_a);
            hq_b.push_front(ref_b);
            while (hq_a.size() > SYNC + 2) void'(hq_a.pop_back());
            while (hq_b.size() > SYNC + 2) void'(hq_b.pop_back());
            lvl[0] = hq_a[SYNC]; prv[0] = hq_a[SYNC + 1];
            lvl[1] = hq_b[SYNC]; prv[1] = hq_b[SYNC + 1];
            both = (m_done[0] != 0) && (m_done[1] != 0);
            e_evt = both;
            if (both) begin
                if (m_meas[0] == m_meas[1])     e_res = 3'b001;
                else if (m_meas[0] > m_meas[1]) e_res = 3'b010;
                else                            e_res = 3'b100;
            end
            for (int ch = 0; ch < 2; ch++) begin
                rs  = (lvl[ch] != 0) && (prv[ch] == 0);
                fl  = (lvl[ch] == 0) && (prv[ch] != 0);
                cap = (m_open[ch] != 0) && (full_period ? rs : fl);
                if (cap) m_meas[ch] = ((cyc - m_start[ch]) > CMAX) ? CMAX : (cyc - m_start[ch]);
                if (rs) begin
                    m_start[ch] = cyc;
                    m_open[ch]  = 1;
                end else if (cap) begin
                    m_open[ch] = 0;
                end
                if (cap)       m_done[ch] = 1;
                else if (both) m_done[ch] = 0;
            end
        end
        model_ok = 1'b1;
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_ok && !finished) begin
            check({a_faster, b_faster, equal_w} == e_res, "R2/R3/R5/R6/R7 verdict",
                  int'({a_faster, b_faster, equal_w}), int'(e_res));
            check(cmp_event == e_evt, "R9 event", int'(cmp_event), int'(e_evt));
            check($countones({a_faster, b_faster, equal_w}) <= 1, "R8 exclusive",
                  $countones({a_faster, b_faster, equal_w}), 1);
            if (cmp_event) evt_seen++;
        end
    end

    task automatic apply_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0;
        full_period = mode;
        repeat (3) @(negedge clk);
        check({a_faster, b_faster, equal_w, cmp_event} == 4'b0000, "R1 reset clears",
              int'({a_faster, b_faster, equal_w, cmp_event}), 0);
        rst_n = 1'b1;
        evt_seen = 0;
    endtask

    task automatic run_phase(input bit mode, input int ha, input int la,
                             input int hb, input int lb, input int len);
        @(negedge clk);
        hi_a = ha; lo_a = la; hi_b = hb; lo_b = lb;
        repeat (900) @(negedge clk);
        apply_reset(mode);
        repeat (len) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check({a_faster, b_faster, equal_w, cmp_event} == 4'b0000, "R1 initial reset",
              int'({a_faster, b_faster, equal_w, cmp_event}), 0);
        rst_n = 1'b1;

        // High-phase mode, A shorter high phase -> A faster.
        run_phase(1'b0, 20, 20, 30, 30, 400);
        check({a_faster, b_faster, equal_w} == 3'b100, "R2/R7 A faster", int'({a_faster, b_faster, equal_w}), 4);
        check(evt_seen > 0, "R9 events raised", evt_seen, 1);

        // High-phase mode, B shorter -> B faster.
        run_phase(1'b0, 30, 30, 20, 20, 400);
        check({a_faster, b_faster, equal_w} == 3'b010, "R6 B faster", int'({a_faster, b_faster, equal_w}), 2);

        // Equal high phases -> equal.
        run_phase(1'b0, 25, 25, 25, 25, 400);
        check({a_faster, b_faster, equal_w} == 3'b001, "R5 equal", int'({a_faster, b_faster, equal_w}), 1);

        // Full-period mode: A period 50 (high 40), B period 60 (high 10) -> A faster.
        run_phase(1'b1, 40, 10, 10, 50, 500);
        check({a_faster, b_faster, equal_w} == 3'b100, "R3 full period", int'({a_faster, b_faster, equal_w}), 4);

        // Channel B silent: A keeps capturing but nothing is compared.
        @(negedge clk);
        en_b = 1'b0;
        run_phase(1'b0, 20, 20, 30, 30, 400);
        check(evt_seen == 0, "R4 no event with one channel", evt_seen, 0);
        check({a_faster, b_faster, equal_w} == 3'b000, "R4 no verdict with one channel",
              int'({a_faster, b_faster, equal_w}), 0);
        en_b = 1'b1;

        // Both spans exceed the counter range -> both saturate -> equal.
        run_phase(1'b0, 300, 300, 400, 400, 3000);
        check({a_faster, b_faster, equal_w} == 3'b001, "R10 saturation", int'({a_faster, b_faster, equal_w}), 1);
        check(evt_seen > 0, "R10 saturated compare happened", evt_seen, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule